// File: doc/BRIEF.md
# Debug Address-Match Interrupt Unit

This block watches the processor's program fetch address and raises a debug interrupt request when that address meets a condition chosen by software. The fetch address is 24 bits wide. An 8-bit bank value forms its upper part and a 16-bit program counter forms its lower part. Software loads two 24-bit compare values and a control byte over a small byte-wide register bus. It can then trap on an exact match with either compare value, on a match with either one, or on any fetch that falls outside the inclusive window the two values bound.

Each fetch address is qualified by a valid strobe. The unit produces a request pulse one cycle long, one clock after each qualified fetch that meets the condition. A stalled fetch with the strobe low produces no further request. The block has two reset inputs. Power-on reset clears all configuration. Hardware or software reset only clears the pending pulse, so debug settings survive a warm restart.

Top module: `dbg_match_unit`

## Requirements
- R1: The compared address is {fetch_bank, fetch_pc}. Register offset 0 is control. Offsets 1, 2 and 3 hold compare value A as bits [7:0], [15:8] and [23:16]. Offsets 4, 5 and 6 hold compare value B in the same byte order. Each byte reads back as written, and offset 7 reads 0x00.
- R2: Control bits [2:0] give the condition. 001 fires on address == A, 010 fires on address == B, and 011 fires when either equality holds.
- R3: Code 101 fires when the address is strictly below A or strictly above B. Addresses equal to A or B do not fire.
- R4: Codes 000, 100, 110 and 111 never produce a request, for any address.
- R5: Control bit 5 is the enable. While it is 0, no request is produced. A single write that sets both the condition code and the enable takes effect at once.
- R6: irq_req goes high in the clock cycle after a cycle with fetch_valid = 1 whose address meets the enabled condition, and it stays high for one cycle only. Without fetch_valid there is no request, even if the address meets the condition.
- R7: A control read returns bit 7 = 1 and bits 6, 4 and 3 = 0. Writing ones to bits 6, 4 and 3 has no effect.
- R8: While por is high, control reads 0x80, all compare bytes read 0x00 and irq_req is 0.
- R9: rst clears irq_req but keeps the control and compare contents. Bus writes are ignored while rst or por is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware/software reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational from reg_addr) |
| fetch_valid | input | 1 | Marks a new fetch address this cycle |
| fetch_bank | input | 8 | Fetch bank, address bits [23:16] |
| fetch_pc | input | 16 | Program counter, address bits [15:0] |
| irq_req | output | 1 | Debug interrupt request pulse |

## Verification
The bench runs every one of the eight condition codes, with the enable both off and on, against addresses at each compare bound, one below it and one above it. It also uses an address that differs only in the bank byte. This exposes a window check that uses inclusive rather than strict comparison, a comparator that ignores the bank byte, and a reserved code that is decoded as a live one. Separate checks cover a stalled address with the strobe low, a pulse that lasts more than one cycle, fixed control bits that can be written, and a warm reset that wipes the configuration or lets a write through.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

    localparam int BANK_W  = 8;
    localparam int PC_W    = 16;
    localparam int BYTE_W  = 8;
    localparam int REG_AW  = 3;

    typedef enum logic [2:0] {
        SEL_OFF0    = 3'b000,
        SEL_EQ_A    = 3'b001,
        SEL_EQ_B    = 3'b010,
        SEL_EQ_ANY  = 3'b011,
        SEL_OFF4    = 3'b100,
        SEL_OUTSIDE = 3'b101,
        SEL_OFF6    = 3'b110,
        SEL_OFF7    = 3'b111
    } match_sel_e;

    typedef struct packed {
        logic       en;
        match_sel_e sel;
    } dbg_ctrl_t;

    localparam int CTRL_EN_BIT = 5;

    function automatic logic [BYTE_W-1:0] ctrl_image(dbg_ctrl_t c);
        return {1'b1, 1'b0, c.en, 2'b00, c.sel};
    endfunction

    function automatic logic sel_hit(match_sel_e s, logic eq_a, logic eq_b,
                                     logic below_a, logic above_b);
        case (s)
            SEL_EQ_A:    return eq_a;
            SEL_EQ_B:    return eq_b;
            SEL_EQ_ANY:  return eq_a | eq_b;
            SEL_OUTSIDE: return below_a | above_b;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_match_regs.sv
module dbg_match_regs
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              wr_en,
    input  logic [AW-1:0]     reg_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output dbg_ctrl_t         ctrl,
    output logic [ADDR_W-1:0] cmp_a,
    output logic [ADDR_W-1:0] cmp_b
);
    localparam int NBYTES = ADDR_W / BYTE_W;
    localparam int NCMP   = 2;

    dbg_ctrl_t         ctrl_q;
    logic [BYTE_W-1:0] cmp_q [NCMP][NBYTES];
    logic              wr_ok;

    assign wr_ok = wr_en && !rst && !por;

    always_ff @(posedge clk) begin
        if (por) begin
            ctrl_q <= '0;
            for (int r = 0; r < NCMP; r++)
                for (int b = 0; b < NBYTES; b++)
                    cmp_q[r][b] <= '0;
        end else if (wr_ok) begin
            if (reg_addr == AW'(0)) begin
                ctrl_q.en  <= wr_data[CTRL_EN_BIT];
                ctrl_q.sel <= match_sel_e'(wr_data[2:0]);
            end
            for (int r = 0; r < NCMP; r++)
                for (int b = 0; b < NBYTES; b++)
                    if (reg_addr == AW'(1 + r * NBYTES + b))
                        cmp_q[r][b] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_addr == AW'(0))
            rd_data = ctrl_image(ctrl_q);
        for (int r = 0; r < NCMP; r++)
            for (int b = 0; b < NBYTES; b++)
                if (reg_addr == AW'(1 + r * NBYTES + b))
                    rd_data = cmp_q[r][b];
    end

    always_comb begin
        for (int b = 0; b < NBYTES; b++) begin
            cmp_a[b*BYTE_W +: BYTE_W] = cmp_q[0][b];
            cmp_b[b*BYTE_W +: BYTE_W] = cmp_q[1][b];
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/dbg_addr_compare.sv
module dbg_addr_compare
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cmp_a,
    input  logic [ADDR_W-1:0] cmp_b,
    input  dbg_ctrl_t         ctrl,
    output logic              hit
);
    logic eq_a, eq_b, below_a, above_b;

    assign eq_a    = (addr == cmp_a);
    assign eq_b    = (addr == cmp_b);
    assign below_a = (addr <  cmp_a);
    assign above_b = (addr >  cmp_b);

    assign hit = ctrl.en & sel_hit(ctrl.sel, eq_a, eq_b, below_a, above_b);
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbg_match_pkg::*;
#(
    parameter int BANK_BITS = BANK_W,
    parameter int PC_BITS   = PC_W,
    parameter int REG_BITS  = REG_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  logic                 wr_en,
    input  logic [REG_BITS-1:0]  reg_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [BYTE_W-1:0]    rd_data,
    input  logic                 fetch_valid,
    input  logic [BANK_BITS-1:0] fetch_bank,
    input  logic [PC_BITS-1:0]   fetch_pc,
    output logic                 irq_req
);
    localparam int ADDR_W = BANK_BITS + PC_BITS;

    dbg_ctrl_t         ctrl_w;
    logic [ADDR_W-1:0] cmp_a_w, cmp_b_w, fetch_addr;
    logic              hit_w;

    assign fetch_addr = {fetch_bank, fetch_pc};

    dbg_match_regs #(.ADDR_W(ADDR_W), .AW(REG_BITS)) u_regs (
        .clk(clk), .rst(rst), .por(por), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .ctrl(ctrl_w), .cmp_a(cmp_a_w), .cmp_b(cmp_b_w)
    );

    dbg_addr_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .addr(fetch_addr), .cmp_a(cmp_a_w), .cmp_b(cmp_b_w),
        .ctrl(ctrl_w), .hit(hit_w)
    );

    always_ff @(posedge clk) begin
        if (por || rst) irq_req <= 1'b0;
        else            irq_req <= fetch_valid & hit_w;
    end
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int AW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              por,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              irq_req,
    input dbg_ctrl_t         ctrl,
    input logic [ADDR_W-1:0] cmp_a,
    input logic [ADDR_W-1:0] cmp_b,
    input logic [AW-1:0]     reg_addr,
    input logic [BYTE_W-1:0] rd_data
);
    a_r6_req_follows_fetch: assert property (@(posedge clk) disable iff (rst || por)
        irq_req |-> $past(fetch_valid));

    a_r5_req_needs_enable: assert property (@(posedge clk) disable iff (rst || por)
        irq_req |-> $past(ctrl.en));

    a_r4_reserved_silent: assert property (@(posedge clk) disable iff (rst || por)
        irq_req |-> ($past(ctrl.sel) inside {SEL_EQ_A, SEL_EQ_B, SEL_EQ_ANY, SEL_OUTSIDE}));

    a_r3_outside_strict: assert property (@(posedge clk) disable iff (rst || por)
        (irq_req && $past(ctrl.sel) == SEL_OUTSIDE) |->
        ($past(fetch_addr) < $past(cmp_a) || $past(fetch_addr) > $past(cmp_b)));

    a_r7_fixed_bits: assert property (@(posedge clk) disable iff (por)
        (reg_addr == AW'(0)) |-> (rd_data[7] && !rd_data[6] && rd_data[4:3] == 2'b00));

    a_r9_warm_retain: assert property (@(posedge clk) disable iff (por)
        rst |=> ($stable(ctrl) && $stable(cmp_a) && $stable(cmp_b) && !irq_req));

    a_r8_por_clears: assert property (@(posedge clk)
        por |=> (ctrl == '0 && cmp_a == '0 && cmp_b == '0 && !irq_req));
endmodule

bind dbg_match_unit dbg_match_unit_chk #(.ADDR_W(ADDR_W), .AW(REG_BITS)) u_chk (
    .clk(clk), .rst(rst), .por(por), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .irq_req(irq_req), .ctrl(ctrl_w),
    .cmp_a(cmp_a_w), .cmp_b(cmp_b_w), .reg_addr(reg_addr), .rd_data(rd_data)
);

// File: tb/dbg_match_unit_tb.sv
module dbg_match_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] CA = 24'h123400;
    localparam logic [23:0] CB = 24'h123480;
    localparam int NADDR = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       fetch_valid = 1'b0;
    logic [7:0] fetch_bank = '0;
    logic [15:0] fetch_pc = '0;
    logic       irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [23:0] probe [NADDR];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_match_unit u_dut (
        .clk(clk), .rst(rst), .por(por), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .fetch_valid(fetch_valid),
        .fetch_bank(fetch_bank), .fetch_pc(fetch_pc), .irq_req(irq_req)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    function automatic bit exp_hit(int m, bit e, logic [23:0] a);
        if (!e) return 1'b0;
        case (m)
            1: return a == CA;
            2: return a == CB;
            3: return (a == CA) || (a == CB);
            5: return (a < CA) || (a > CB);
            default: return 1'b0;
        endcase
    endfunction

    // drive one qualified fetch; return the request seen one cycle later
    task automatic fetch(logic [23:0] a, output logic req_now, output logic req_next);
        @(negedge clk);
        fetch_valid = 1'b1; {fetch_bank, fetch_pc} = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        req_now = irq_req;
        @(negedge clk);
        req_next = irq_req;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic r0, r1;
        probe[0] = CA - 24'd1; probe[1] = CA; probe[2] = CA + 24'd1;
        probe[3] = CB - 24'd1; probe[4] = CB; probe[5] = CB + 24'd1;
        probe[6] = 24'h000000; probe[7] = 24'hFFFFFF; probe[8] = 24'h133400;

        repeat (3) @(posedge clk);
        // R8: state held in power-on reset
        rd(3'd0, d); check("R8 ctrl during por", {24'd0, d}, 32'h80);
        rd(3'd2, d); check("R8 cmp byte during por", {24'd0, d}, 32'h00);
        check("R8 irq during por", {31'd0, irq_req}, 32'd0);
        @(negedge clk); por = 1'b0;

        // R1: compare bytes, least significant first
        wr(3'd1, CA[7:0]); wr(3'd2, CA[15:8]); wr(3'd3, CA[23:16]);
        wr(3'd4, CB[7:0]); wr(3'd5, CB[15:8]); wr(3'd6, CB[23:16]);
        for (int i = 0; i < 3; i++) begin
            rd(3'(1 + i), d); check("R1 cmp A byte", {24'd0, d}, {24'd0, CA[i*8 +: 8]});
            rd(3'(4 + i), d); check("R1 cmp B byte", {24'd0, d}, {24'd0, CB[i*8 +: 8]});
        end
        rd(3'd7, d); check("R1 offset 7", {24'd0, d}, 32'h00);

        // R7: fixed bits
        wr(3'd0, 8'hFF); rd(3'd0, d); check("R7 fixed bits", {24'd0, d}, 32'hA7);

        // R2 R3 R4 R5: full sweep of codes, enable and probe addresses
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 2; e++) begin
                wr(3'd0, 8'h58 | (e[0] ? 8'h20 : 8'h00) | 8'(m));
                for (int k = 0; k < NADDR; k++) begin
                    fetch(probe[k], r0, r1);
                    if (m == 5)
                        check("R3 outside window", {31'd0, r0}, {31'd0, exp_hit(m, e[0], probe[k])});
                    else if (m == 0 || m == 4 || m >= 6)
                        check("R4 reserved code", {31'd0, r0}, {31'd0, exp_hit(m, e[0], probe[k])});
                    else if (e == 0)
                        check("R5 disabled", {31'd0, r0}, 32'd0);
                    else
                        check("R2 equality", {31'd0, r0}, {31'd0, exp_hit(m, e[0], probe[k])});
                    if (r0) check("R6 single pulse", {31'd0, r1}, 32'd0);
                end
            end
        end

        // R6: matching address without strobe
        wr(3'd0, 8'h21);
        @(negedge clk); {fetch_bank, fetch_pc} = CA; fetch_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 no strobe", {31'd0, irq_req}, 32'd0);

        // R9: warm reset keeps settings and blocks writes
        wr(3'd0, 8'h25);
        @(negedge clk); rst = 1'b1; wr_en = 1'b1; reg_addr = 3'd0; wr_data = 8'h00;
        @(negedge clk); reg_addr = 3'd2; wr_data = 8'h99;
        @(negedge clk); wr_en = 1'b0; rst = 1'b0;
        rd(3'd0, d); check("R9 ctrl kept", {24'd0, d}, 32'hA5);
        rd(3'd2, d); check("R9 cmp kept", {24'd0, d}, {24'd0, CA[15:8]});
        fetch(CB + 24'd1, r0, r1);
        check("R9 works after rst", {31'd0, r0}, 32'd1);

        // R8: power-on reset clears everything
        @(negedge clk); por = 1'b1;
        @(negedge clk); @(negedge clk); por = 1'b0;
        rd(3'd0, d); check("R8 ctrl after por", {24'd0, d}, 32'h80);
        rd(3'd6, d); check("R8 cmp after por", {24'd0, d}, 32'h00);
        fetch(24'h000000, r0, r1);
        check("R8 no req after por", {31'd0, r0}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule